// File: doc/BRIEF.md
# Banked Display-RAM Write Address Counter

This block produces the write position for a byte-wide display memory arranged as 5 banks of 101 columns. Each byte holds a vertical strip of 8 pixels, bit 0 being the topmost line of its bank, so bank `b` covers display lines `8b` to `8b+7`. A command decoder outside the block loads the column and bank registers through strobes. The data path pulses `byte_wr` once for every display byte it stores.

After each stored byte the position moves one step. The step follows one of two scan orders, chosen by `vert_mode` at the time of the write. In the horizontal order (`vert_mode` = 0) the column moves first, filling a whole bank row before the bank changes. In the vertical order (`vert_mode` = 1) the bank moves first, filling all five banks of one column before the column changes.

The block presents the bank, the column and a flat memory address `bank*101 + col`. All of these are held in registers or derived from registers, and they change on the clock edge that follows the strobe. The control pins are plain level signals with no handshake, because no data passes through the block.

Top module: `bank_addr_counter`

## Requirements
- R1: While reset is asserted and after it is released, `col_idx` = 0, `bank_idx` = 0 and `ram_addr` = 0.
- R2: A `col_load` pulse places `col_value` in the column register at the next edge when the value is 0 to 100. A value of 101 to 127 loads 0.
- R3: A `bank_load` pulse places `bank_value` in the bank register at the next edge when the value is 0 to 4. A value of 5 to 7 loads 0.
- R4: In any cycle with `col_load` or `bank_load` high, `byte_wr` has no effect. A register that is not loaded keeps its value.
- R5: In horizontal mode (`vert_mode` = 0), a write with column below 100 increments the column and keeps the bank.
- R6: In horizontal mode, a write at column 100 sets the column to 0 and increments the bank. At bank 4 the bank becomes 0.
- R7: In vertical mode (`vert_mode` = 1), a write with bank below 4 increments the bank and keeps the column.
- R8: In vertical mode, a write at bank 4 sets the bank to 0 and increments the column. At column 100 the column becomes 0.
- R9: With no write and no load, column and bank hold their values.
- R10: `ram_addr` always equals `bank_idx*101 + col_idx`, which lies in the range 0 to 504. In horizontal mode, 505 writes from position 0 visit the addresses 0 to 504 in order.
- R11: `vert_mode` is sampled at each write, so switching it mid-stream continues from the current position in the new order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| col_load | input | 1 | Load strobe for the column register |
| col_value | input | 7 | Column to load (0 to 100) |
| bank_load | input | 1 | Load strobe for the bank register |
| bank_value | input | 3 | Bank to load (0 to 4) |
| vert_mode | input | 1 | Scan order: 0 = column first, 1 = bank first |
| byte_wr | input | 1 | One pulse per display byte stored |
| bank_idx | output | 3 | Current bank |
| col_idx | output | 7 | Current column |
| ram_addr | output | 9 | Flat address, bank*101 + col |

## Verification
The bench targets the two wrap points in both orders, and the corner where both wrap at once (column 100 with bank 4). A design with a power-of-two wrap would run on to column 101 or bank 5 there, and a design with the wrong carry would move the wrong register. It loads out-of-range values, where an unclamped design would leave the column or bank off the end of the memory. It applies a load and a write in the same cycle, where a design that gives the write priority would land one step past the loaded position. It also sweeps the whole memory in both orders, which exposes any error in the flat-address multiply or an address that is skipped or repeated.

// File: rtl/bank_addr_pkg.sv
package bank_addr_pkg;
  localparam int unsigned DEF_COLS  = 101;
  localparam int unsigned DEF_BANKS = 5;

  typedef enum logic {
    SCAN_HORIZ = 1'b0,
    SCAN_VERT  = 1'b1
  } scan_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wrap_counter.sv
module wrap_counter #(
  parameter int unsigned LIMIT = 101,
  parameter int unsigned W     = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] value,
  output logic         at_last
);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic in_range;
  assign in_range = (load_val <= LAST);
  assign at_last  = (value == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)
      value <= '0;
    else if (load)
      value <= in_range ? load_val : '0;
    else if (step)
      value <= at_last ? '0 : value + 1'b1;
  end
endmodule

// File: rtl/flat_addr_map.sv
module flat_addr_map #(
  parameter int unsigned COLS   = 101,
  parameter int unsigned COL_W  = 7,
  parameter int unsigned BANK_W = 3,
  parameter int unsigned ADDR_W = 9
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [COL_W-1:0]  col,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(COLS);

  logic [ADDR_W-1:0] bank_base;
  assign bank_base = ADDR_W'(bank) * STRIDE;
  assign addr      = bank_base + ADDR_W'(col);
endmodule

// File: rtl/bank_addr_counter.sv
module bank_addr_counter
  import bank_addr_pkg::*;
#(
  parameter int unsigned COLS   = DEF_COLS,
  parameter int unsigned BANKS  = DEF_BANKS,
  parameter int unsigned COL_W  = idx_width(DEF_COLS),
  parameter int unsigned BANK_W = idx_width(DEF_BANKS),
  parameter int unsigned ADDR_W = idx_width(DEF_COLS * DEF_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              col_load,
  input  logic [COL_W-1:0]  col_value,
  input  logic              bank_load,
  input  logic [BANK_W-1:0] bank_value,
  input  logic              vert_mode,
  input  logic              byte_wr,
  output logic [BANK_W-1:0] bank_idx,
  output logic [COL_W-1:0]  col_idx,
  output logic [ADDR_W-1:0] ram_addr
);
  scan_e order;
  logic  advance, col_step, bank_step, col_last, bank_last;

  assign order   = scan_e'(vert_mode);
  assign advance = byte_wr & ~(col_load | bank_load);

  always_comb begin
    col_step  = 1'b0;
    bank_step = 1'b0;
    unique case (order)
      SCAN_HORIZ: begin
        col_step  = advance;
        bank_step = advance & col_last;
      end
      SCAN_VERT: begin
        bank_step = advance;
        col_step  = advance & bank_last;
      end
    endcase
  end

  wrap_counter #(.LIMIT(COLS), .W(COL_W)) u_col (
    .clk(clk), .rst_n(rst_n), .load(col_load), .load_val(col_value),
    .step(col_step), .value(col_idx), .at_last(col_last)
  );

  wrap_counter #(.LIMIT(BANKS), .W(BANK_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .load(bank_load), .load_val(bank_value),
    .step(bank_step), .value(bank_idx), .at_last(bank_last)
  );

  flat_addr_map #(.COLS(COLS), .COL_W(COL_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_map (
    .bank(bank_idx), .col(col_idx), .addr(ram_addr)
  );
endmodule

// File: rtl/bank_addr_counter_chk.sv
module bank_addr_counter_chk #(
  parameter int unsigned COLS   = 101,
  parameter int unsigned BANKS  = 5,
  parameter int unsigned COL_W  = 7,
  parameter int unsigned BANK_W = 3,
  parameter int unsigned ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              col_load,
  input logic [COL_W-1:0]  col_value,
  input logic              bank_load,
  input logic              vert_mode,
  input logic              byte_wr,
  input logic [BANK_W-1:0] bank_idx,
  input logic [COL_W-1:0]  col_idx,
  input logic [ADDR_W-1:0] ram_addr
);
  localparam int unsigned TOTAL = COLS * BANKS;

  // R10
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ram_addr) < TOTAL);

  // R2
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(col_idx) < COLS) && (32'(bank_idx) < BANKS));

  // R4
  col_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_load && !bank_load && 32'(col_value) < COLS)
      |=> (col_idx == $past(col_value)) && $stable(bank_idx));

  // R5
  horiz_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_wr && !col_load && !bank_load && !vert_mode && 32'(col_idx) < COLS - 1)
      |=> (32'(col_idx) == 32'($past(col_idx)) + 1) && $stable(bank_idx));

  // R7
  vert_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_wr && !col_load && !bank_load && vert_mode && 32'(bank_idx) < BANKS - 1)
      |=> (32'(bank_idx) == 32'($past(bank_idx)) + 1) && $stable(col_idx));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_wr && !col_load && !bank_load) |=> $stable(col_idx) && $stable(bank_idx));
endmodule

bind bank_addr_counter bank_addr_counter_chk #(
  .COLS(COLS), .BANKS(BANKS), .COL_W(COL_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .col_load(col_load), .col_value(col_value),
  .bank_load(bank_load), .vert_mode(vert_mode), .byte_wr(byte_wr),
  .bank_idx(bank_idx), .col_idx(col_idx), .ram_addr(ram_addr)
);

// File: tb/test_bank_addr_counter.sv
module test_bank_addr_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       col_load = 1'b0;
  logic [6:0] col_value = '0;
  logic       bank_load = 1'b0;
  logic [2:0] bank_value = '0;
  logic       vert_mode = 1'b0;
  logic       byte_wr = 1'b0;
  logic [2:0] bank_idx;
  logic [6:0] col_idx;
  logic [8:0] ram_addr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bank_addr_counter i_bank_addr_counter (
    .clk(clk), .rst_n(rst_n), .col_load(col_load), .col_value(col_value),
    .bank_load(bank_load), .bank_value(bank_value), .vert_mode(vert_mode),
    .byte_wr(byte_wr), .bank_idx(bank_idx), .col_idx(col_idx), .ram_addr(ram_addr)
  );

  typedef struct packed {
    logic       cl;
    logic [6:0] cv;
    logic       bl;
    logic [2:0] bv;
    logic       vm;
    logic       wr;
    logic [6:0] ec;
    logic [2:0] eb;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 7'd98,  1'b1, 3'd2, 1'b0, 1'b0, 7'd98,  3'd2, 4'd2},  // R2 R3 in-range loads
    '{1'b0, 7'd0,   1'b0, 3'd0, 1'b0, 1'b1, 7'd99,  3'd2, 4'd5},  // R5
    '{1'b0, 7'd0,   1'b0, 3'd0, 1'b0, 1'b1, 7'd100, 3'd2, 4'd5},  // R5
    '{1'b0, 7'd0,   1'b0, 3'd0, 1'b0, 1'b1, 7'd0,   3'd3, 4'd6},  // R6 column wrap
    '{1'b1, 7'd100, 1'b1, 3'd4, 1'b0, 1'b0, 7'd100, 3'd4, 4'd2},  // R2 R3 top values
    '{1'b0, 7'd0,   1'b0, 3'd0, 1'b0, 1'b1, 7'd0,   3'd0, 4'd6},  // R6 double wrap
    '{1'b0, 7'd0,   1'b1, 3'd3, 1'b0, 1'b0, 7'd0,   3'd3, 4'd3},  // R3
    '{1'b0, 7'd0,   1'b0, 3'd0, 1'b1, 1'b1, 7'd0,   3'd4, 4'd7},  // R7
    '{1'b0, 7'd0,   1'b0, 3'd0, 1'b1, 1'b1, 7'd1,   3'd0, 4'd8},  // R8 bank wrap
    '{1'b1, 7'd100, 1'b1, 3'd4, 1'b1, 1'b0, 7'd100, 3'd4, 4'd2},  // R2
    '{1'b0, 7'd0,   1'b0, 3'd0, 1'b1, 1'b1, 7'd0,   3'd0, 4'd8},  // R8 double wrap
    '{1'b1, 7'd50,  1'b0, 3'd0, 1'b0, 1'b0, 7'd50,  3'd0, 4'd2},  // R2
    '{1'b1, 7'd127, 1'b0, 3'd0, 1'b0, 1'b0, 7'd0,   3'd0, 4'd2},  // R2 out of range
    '{1'b0, 7'd0,   1'b1, 3'd2, 1'b0, 1'b0, 7'd0,   3'd2, 4'd3},  // R3
    '{1'b0, 7'd0,   1'b1, 3'd7, 1'b0, 1'b0, 7'd0,   3'd0, 4'd3},  // R3 out of range
    '{1'b1, 7'd10,  1'b0, 3'd0, 1'b0, 1'b1, 7'd10,  3'd0, 4'd4},  // R4 load beats write
    '{1'b0, 7'd0,   1'b1, 3'd3, 1'b0, 1'b1, 7'd10,  3'd3, 4'd4},  // R4 other reg holds
    '{1'b0, 7'd0,   1'b0, 3'd0, 1'b1, 1'b0, 7'd10,  3'd3, 4'd9},  // R9 idle
    '{1'b0, 7'd0,   1'b0, 3'd0, 1'b0, 1'b1, 7'd11,  3'd3, 4'd11}, // R11 horizontal
    '{1'b0, 7'd0,   1'b0, 3'd0, 1'b1, 1'b1, 7'd11,  3'd4, 4'd11}  // R11 then vertical
  };

  task automatic check(input int rq, input int ec, input int eb);
    int ea;
    ea = eb * 101 + ec;
    n_run++;
    if (int'(col_idx) != ec || int'(bank_idx) != eb || int'(ram_addr) != ea) begin
      n_fail++;
      $display("FAIL R%0d: col=%0d bank=%0d addr=%0d expected col=%0d bank=%0d addr=%0d",
               rq, col_idx, bank_idx, ram_addr, ec, eb, ea);
    end
  endtask

  task automatic step(input logic cl, input logic [6:0] cv, input logic bl,
                      input logic [2:0] bv, input logic vm, input logic wr);
    col_load = cl; col_value = cv; bank_load = bl; bank_value = bv;
    vert_mode = vm; byte_wr = wr;
    @(posedge clk);
    @(negedge clk);
    col_load = 1'b0; bank_load = 1'b0; byte_wr = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    check(1, 0, 0);  // R1 during reset
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(1, 0, 0);  // R1 after release

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].cl, VECS[i].cv, VECS[i].bl, VECS[i].bv, VECS[i].vm, VECS[i].wr);
      check(int'(VECS[i].rq), int'(VECS[i].ec), int'(VECS[i].eb));
    end

    // R1 reset mid-run clears a nonzero position
    rst_n = 1'b0;
    @(negedge clk);
    check(1, 0, 0);
    rst_n = 1'b1;

    // R10 horizontal sweep: address k after k writes, wrap to 0 after 505
    for (int k = 1; k <= 505; k++) begin
      step(1'b0, 7'd0, 1'b0, 3'd0, 1'b0, 1'b1);
      check(10, (k % 505) % 101, (k % 505) / 101);
    end

    // R8 vertical sweep: bank cycles fastest, column after every 5 writes
    for (int k = 1; k <= 505; k++) begin
      step(1'b0, 7'd0, 1'b0, 3'd0, 1'b1, 1'b1);
      check(8, (k % 505) / 5, (k % 505) % 5);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule